// File: doc/BRIEF.md
# Temperature Alarm with Fault Queue

This block watches a stream of signed temperature conversion results and drives two alarm pins. One is an over-temperature pin that always works as a comparator. The other is an alert pin that can work either as a comparator or as a latched interrupt that software clears by reading the temperature. A trip point and a hysteresis amount set the thresholds. The upper threshold is the trip point itself, and the lower threshold is the trip point minus the hysteresis.

Each output tracks which side of the band it is on. A change of side needs a run of consecutive qualifying conversions. The run is one conversion long when the fault queue is off and four long when it is on. Configuration inputs set the queue, the interrupt mode, the polarity of each pin and a shutdown mode. In shutdown the block ignores conversion strobes and keeps all of its state. The conversion source and the register access logic sit outside this block.

Top module: `temp_alarm`

## Requirements
- R1: After reset both alarms are inactive, so with both polarity inputs at 0 both pins read 1.
- R2: With the fault queue off, a single conversion strictly above the trip point makes a comparator output active on the clock edge that accepts that conversion.
- R3: With the fault queue on, a comparator output changes side only on the fourth consecutive conversion that meets the pending condition.
- R4: A conversion that does not meet the pending condition restarts the consecutive count from zero.
- R5: An active comparator output returns inactive only on a conversion strictly below the trip point minus the hysteresis. Conversions between the two thresholds, or equal to the lower one, leave it active.
- R6: In interrupt mode the alert becomes active when a queued hot event occurs and stays active until a temperature-read strobe clears it. The over-temperature pin ignores the read strobe.
- R7: After an interrupt-mode hot event, the alert asserts again only on a queued cool event below the lower threshold. Further hot conversions do not assert it.
- R8: Each polarity input set to 1 makes its pin active-high, and set to 0 makes it active-low. A polarity change shows on the pin at once.
- R9: While shutdown is set, conversion strobes are ignored and both pins hold their state.
- R10: Temperatures, the trip point and the hysteresis are compared as signed two's-complement values.
- R11: A conversion equal to the trip point is not a hot conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: new conversion result |
| conv_temp | input | TW | Signed conversion result |
| cfg_queue | input | 1 | 1: four-deep fault queue, 0: single conversion |
| cfg_alert_hi | input | 1 | Alert polarity, 1 active-high |
| cfg_ot_hi | input | 1 | Over-temperature polarity, 1 active-high |
| cfg_intr | input | 1 | 1: alert in interrupt mode, 0: comparator |
| cfg_sdown | input | 1 | Shutdown, ignore conversions |
| lim_high | input | TW | Signed trip point |
| lim_hyst | input | TW | Signed hysteresis amount |
| temp_rd | input | 1 | Strobe: temperature register was read |
| alert_o | output | 1 | Alert pin |
| ot_o | output | 1 | Over-temperature pin |

## Verification
A corrupted consecutive counter makes a pin switch one or more conversions early or late. That shows on the edge that accepts the wrong conversion, so the bench samples right after every strobe. A wrong side register leaves a pin stuck or switching on the wrong threshold, which the first conversion on the far side of the band exposes. A stale interrupt flag stays visible on the alert pin until the next read, and the bench looks for it right after each read and each strobe that should not set it.

// File: rtl/temp_alarm.sv
module temp_alarm #(
  parameter int TW     = 13,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [TW-1:0] conv_temp,
  input  logic          cfg_queue,
  input  logic          cfg_alert_hi,
  input  logic          cfg_ot_hi,
  input  logic          cfg_intr,
  input  logic          cfg_sdown,
  input  logic [TW-1:0] lim_high,
  input  logic [TW-1:0] lim_hyst,
  input  logic          temp_rd,
  output logic          alert_o,
  output logic          ot_o
);
  localparam int CW  = $clog2(QDEPTH + 1);
  localparam int NCH = 2;

  logic signed [TW:0] t_x, hi_x, lo_x;
  logic               hot, cool, take;
  logic [CW-1:0]      need;
  logic [NCH-1:0]     side, ev;
  logic               flag;
  logic               alert_act;

  assign t_x  = {conv_temp[TW-1], conv_temp};
  assign hi_x = {lim_high[TW-1], lim_high};
  assign lo_x = hi_x - {lim_hyst[TW-1], lim_hyst};
  assign hot  = t_x > hi_x;
  assign cool = t_x < lo_x;
  assign take = conv_valid & ~cfg_sdown;
  assign need = cfg_queue ? CW'(QDEPTH) : CW'(1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] cnt;
    logic          meet, last;
    assign meet   = side[ch] ? cool : hot;
    assign last   = cnt >= need - CW'(1);
    assign ev[ch] = take & meet & last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        side[ch] <= 1'b0;
        cnt      <= '0;
      end else if (take) begin
        if (!meet) begin
          cnt <= '0;
        end else if (last) begin
          side[ch] <= ~side[ch];
          cnt      <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (!cfg_intr) flag <= 1'b0;
    else if (ev[0])    flag <= 1'b1;
    else if (temp_rd)  flag <= 1'b0;
  end

  assign alert_act = cfg_intr ? flag : side[0];
  assign alert_o   = cfg_alert_hi ? alert_act : ~alert_act;
  assign ot_o      = cfg_ot_hi ? side[1] : ~side[1];
endmodule

module temp_alarm_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_valid,
  input logic cfg_queue,
  input logic cfg_alert_hi,
  input logic cfg_ot_hi,
  input logic cfg_intr,
  input logic cfg_sdown,
  input logic temp_rd,
  input logic alert_o,
  input logic ot_o
);
  logic [4:0] cfgv;
  logic       ot_act, al_act, prev_ot, prev_q;
  logic [2:0] run;

  assign cfgv   = {cfg_queue, cfg_alert_hi, cfg_ot_hi, cfg_intr, cfg_sdown};
  assign ot_act = cfg_ot_hi ? ot_o : ~ot_o;
  assign al_act = cfg_alert_hi ? alert_o : ~alert_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ot <= 1'b0;
      prev_q  <= 1'b0;
      run     <= '0;
    end else begin
      prev_ot <= ot_act;
      prev_q  <= cfg_queue;
      if (ot_act != prev_ot || cfg_queue != prev_q)
        run <= {2'b00, conv_valid & ~cfg_sdown};
      else if (conv_valid && !cfg_sdown && run != 3'd7)
        run <= run + 3'd1;
    end
  end

  // R2
  ot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_act != $past(ot_act) && cfgv == $past(cfgv)) |-> $past(conv_valid && !cfg_sdown));

  // R3
  queue_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_queue && cfg_queue == prev_q && ot_act != prev_ot) |-> run >= 3'd4);

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_intr && temp_rd && !conv_valid) |=> (!al_act || cfgv != $past(cfgv)));

  // R8
  ot_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ot_hi != $past(cfg_ot_hi) && !$past(conv_valid)) |-> ot_o != $past(ot_o));

  // R9
  sdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sdown && !temp_rd) |=> ((ot_o == $past(ot_o) && alert_o == $past(alert_o))
                                 || cfgv != $past(cfgv)));
endmodule

bind temp_alarm temp_alarm_chk u_chk (.*);

// File: tb/sim_temp_alarm.sv
module sim_temp_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 13;

  logic          clk = 0, rst_n = 0, conv_valid = 0, temp_rd = 0;
  logic [TW-1:0] conv_temp = '0, lim_high = '0, lim_hyst = '0;
  logic          cfg_queue = 0, cfg_alert_hi = 0, cfg_ot_hi = 0, cfg_intr = 0, cfg_sdown = 0;
  logic          alert_o, ot_o;
  int            checks = 0, failures = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alarm u0 (.*);

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic start(bit q, bit ah, bit oh, bit im, bit sd, int hi, int hy);
    @(negedge clk);
    rst_n = 0;
    cfg_queue = q; cfg_alert_hi = ah; cfg_ot_hi = oh; cfg_intr = im; cfg_sdown = sd;
    lim_high = TW'(hi); lim_hyst = TW'(hy);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic conv(int t);
    conv_temp = TW'(t); conv_valid = 1;
    @(negedge clk);
    conv_valid = 0;
  endtask

  task automatic rd();
    temp_rd = 1;
    @(negedge clk);
    temp_rd = 0;
  endtask

  task automatic t_reset();
    start(0, 0, 0, 0, 0, 100, 20);
    chk("R1 alert", alert_o, 1'b1);
    chk("R1 ot", ot_o, 1'b1);
  endtask

  task automatic t_single();
    start(0, 1, 1, 0, 0, 100, 20);
    conv(100); chk("R11 ot", ot_o, 0); chk("R11 alert", alert_o, 0);
    conv(101); chk("R2 ot", ot_o, 1); chk("R2 alert", alert_o, 1);
    conv(90);  chk("R5 mid", ot_o, 1);
    conv(80);  chk("R5 equal low", ot_o, 1); chk("R5 equal low alert", alert_o, 1);
    conv(79);  chk("R5 below", ot_o, 0); chk("R5 below alert", alert_o, 0);
  endtask

  task automatic t_queue();
    start(1, 1, 1, 0, 0, 100, 20);
    for (int i = 0; i < 3; i++) conv(120);
    chk("R3 three hot", ot_o, 0);
    conv(50); chk("R4 break", ot_o, 0);
    for (int i = 0; i < 3; i++) conv(120);
    chk("R4 restarted", ot_o, 0); chk("R4 restarted alert", alert_o, 0);
    conv(120); chk("R3 fourth", ot_o, 1); chk("R3 fourth alert", alert_o, 1);
    conv(70); conv(70); conv(90);
    for (int i = 0; i < 3; i++) conv(70);
    chk("R4 cool break", ot_o, 1);
    conv(70); chk("R3 cool fourth", ot_o, 0); chk("R3 cool fourth alert", alert_o, 0);
  endtask

  task automatic t_intr();
    start(0, 1, 1, 1, 0, 100, 20);
    conv(110); chk("R6 set", alert_o, 1); chk("R6 ot", ot_o, 1);
    rd();      chk("R6 cleared", alert_o, 0); chk("R6 ot ignores read", ot_o, 1);
    conv(110); chk("R7 no hot reassert", alert_o, 0);
    conv(70);  chk("R7 cool event", alert_o, 1); chk("R7 ot", ot_o, 0);
    rd();      chk("R6 cleared again", alert_o, 0);
    conv(70);  chk("R7 no cool reassert", alert_o, 0);
    conv(110); chk("R7 hot again", alert_o, 1);
  endtask

  task automatic t_pol();
    start(0, 0, 0, 0, 0, 100, 20);
    conv(110); chk("R8 low alert", alert_o, 0); chk("R8 low ot", ot_o, 0);
    cfg_alert_hi = 1; #1;
    chk("R8 flip alert", alert_o, 1); chk("R8 ot kept", ot_o, 0);
    @(negedge clk); cfg_ot_hi = 1; #1;
    chk("R8 flip ot", ot_o, 1);
    @(negedge clk);
  endtask

  task automatic t_sdown();
    start(0, 1, 1, 0, 1, 100, 20);
    conv(110); chk("R9 ignored", ot_o, 0); chk("R9 ignored alert", alert_o, 0);
    cfg_sdown = 0;
    conv(110); chk("R9 resumed", ot_o, 1);
    cfg_sdown = 1;
    conv(0);   chk("R9 held", ot_o, 1); chk("R9 held alert", alert_o, 1);
  endtask

  task automatic t_signed();
    start(0, 1, 1, 0, 0, -10, 5);
    conv(-20);  chk("R10 below neg limit", ot_o, 0);
    conv(-5);   chk("R10 above neg limit", ot_o, 1);
    conv(-12);  chk("R10 in band", ot_o, 1);
    conv(-15);  chk("R10 equal low", ot_o, 1);
    conv(-16);  chk("R10 below low", ot_o, 0);
    conv(4095); chk("R10 max positive", ot_o, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_queue();
    t_intr();
    t_pol();
    t_sdown();
    t_signed();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule